// File: doc/BRIEF.md
# SPI NOR Page-Program Splitter

This block turns one write request (a 24-bit start address, a byte count and a stream of data bytes) into the sequence of SPI flash commands that stores those bytes. A program command may never wrap past a 256-byte page. The block therefore cuts the request into chunks. The first chunk runs only up to the next page boundary. Each later chunk starts on a page boundary and covers at most one page.

Before each chunk the block reads the device status until the device is idle. It then sends a write-enable frame, followed by the program frame with that chunk's address and data. The block keeps a running count of the data bytes it has sent, so the requester knows how much of the request reached the device.

The block drives a byte-wide transfer port to an external SPI shifter: a chip-select plus a valid/ready byte handshake. The shifter returns the byte it received in the cycle of each accepted transfer.

Data enters on a valid/ready stream. The block raises `in_ready` only during the data part of a program frame, and only while the shifter accepts a byte, so a byte is consumed exactly when `in_valid && in_ready`. The source may drop `in_valid` at any time; the program frame then waits with chip-select held low. Outside data phases the stream is held off.

Top module: `pp_split_top`

## Requirements
- R1: The first program chunk has length `len` when `(addr mod 256) + len <= 256`, and `256 - (addr mod 256)` otherwise.
- R2: Every later chunk starts at the request address plus the data bytes already sent, and has length min(remaining bytes, 256).
- R3: A program frame is one chip-select-low period holding byte 0x02, then the address as three bytes with the most significant first, then the chunk's data bytes in stream order. No transfer is presented while chip-select is high.
- R4: Before each chunk the block sends status-read frames. Each is exactly two bytes: 0x05, then a filler byte, with the byte returned during the filler read as status. Only bit 0 of the status marks the device busy; the other bits are ignored. Polling repeats until bit 0 is clear. A one-byte write-enable frame 0x06 then follows.
- R5: `wr_count` is cleared when a request is accepted and rises by one for each data byte sent. The command and address bytes are not counted, and the count is final when `done` pulses.
- R6: A request with length 0 completes with `err` low and `wr_count` 0. Chip-select does not fall and no stream byte is consumed.
- R7: A request with `addr + len > DEV_BYTES` completes with `err` high and `wr_count` 0, and causes no bus activity. A request ending exactly at `DEV_BYTES` is accepted.
- R8: After `POLL_MAX` consecutive busy status reads before a chunk, the request ends with `err` high. `wr_count` then holds the bytes of the chunks already completed, which is 0 when the timeout happens before the first chunk.
- R9: `in_ready` is high only in the data phase of a program frame. The number of stream bytes consumed equals the number of data bytes sent.
- R10: `req_ready` is high only while idle, and a request is taken on `req_valid && req_ready`. `done` is a single-cycle pulse per request.
- R11: Chip-select returns high for at least one cycle between any two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_addr | input | 24 | Start byte address |
| req_len | input | LEN_W | Byte count |
| in_valid | input | 1 | Stream byte present |
| in_ready | output | 1 | Stream byte taken this cycle if valid |
| in_data | input | 8 | Stream byte |
| spi_cs_n | output | 1 | Chip-select to the shifter, low during a frame |
| spi_tx_valid | output | 1 | Byte to transfer is presented |
| spi_tx_ready | input | 1 | Shifter completes the presented byte this cycle |
| spi_tx_data | output | 8 | Byte to transfer |
| spi_rx_data | input | 8 | Byte received, valid in the cycle of a completed transfer |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request rejected or timed out; valid with `done`, held until the next request |
| wr_count | output | LEN_W | Data bytes written for the current request |

## Verification
An internal fault shows up at the shifter port within a single frame. A wrong address or remaining-count register appears in the next program frame's address bytes or length, which is at most one page of transfers later. A stuck poll counter appears as an extra or missing status frame, or as a premature error, before the chunk it guards. Any byte sent from the wrong address shows as a data mismatch against the address-derived stream pattern. A mis-gated stream shows as a stream byte consumed outside a data phase, in the same cycle that it happens.

// File: rtl/pp_split_pkg.sv
package pp_split_pkg;
  localparam int ADDR_W = 24;

  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_STATUS = 8'h05;
  localparam logic [7:0] OP_FILL   = 8'h00;
  localparam logic [7:0] BUSY_MASK = 8'h01;

  typedef enum logic [3:0] {
    S_IDLE,
    S_POLL_OP,
    S_POLL_RD,
    S_POLL_GAP,
    S_WREN,
    S_WREN_GAP,
    S_PP_OP,
    S_PP_A2,
    S_PP_A1,
    S_PP_A0,
    S_PP_DAT,
    S_PP_GAP,
    S_DONE
  } seq_state_e;
endpackage

// File: rtl/pp_req_check.sv
module pp_req_check
  import pp_split_pkg::*;
#(
  parameter int          LEN_W     = 16,
  parameter int unsigned DEV_BYTES = 32'd16777216
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  output logic              is_empty,
  output logic              out_of_range
);
  logic [32:0] end_pos;

  always_comb begin
    end_pos      = 33'(addr) + 33'(len);
    is_empty     = (len == '0);
    out_of_range = end_pos > 33'(DEV_BYTES);
  end
endmodule

// File: rtl/pp_chunk_calc.sv
module pp_chunk_calc #(
  parameter int PAGE_BYTES = 256,
  parameter int LEN_W      = 16,
  localparam int PAGE_W    = $clog2(PAGE_BYTES),
  localparam int CHUNK_W   = PAGE_W + 1
) (
  input  logic [PAGE_W-1:0]  page_off,
  input  logic [LEN_W-1:0]   remain,
  output logic [CHUNK_W-1:0] chunk_len
);
  logic [CHUNK_W-1:0] room;

  // Bytes left before the next page boundary; a full page when aligned.
  always_comb begin
    room      = CHUNK_W'(PAGE_BYTES) - {1'b0, page_off};
    chunk_len = (remain <= LEN_W'(room)) ? remain[CHUNK_W-1:0] : room;
  end
endmodule

// File: rtl/pp_poll_limit.sv
module pp_poll_limit #(
  parameter int POLL_MAX = 100000,
  localparam int CNT_W   = $clog2(POLL_MAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + CNT_W'(1);
  end

  assign last = (cnt == CNT_W'(POLL_MAX - 1));
endmodule

// File: rtl/pp_split_seq.sv
module pp_split_seq
  import pp_split_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int CHUNK_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [LEN_W-1:0]   req_len,
  input  logic               req_empty,
  input  logic               req_oor,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         in_data,
  output logic               spi_cs_n,
  output logic               spi_tx_valid,
  input  logic               spi_tx_ready,
  output logic [7:0]         spi_tx_data,
  input  logic [7:0]         spi_rx_data,
  output logic [ADDR_W-1:0]  cur_addr,
  output logic [LEN_W-1:0]   remain,
  input  logic [CHUNK_W-1:0] chunk_len,
  output logic               poll_clr,
  output logic               poll_inc,
  input  logic               poll_last,
  output logic               done,
  output logic               err,
  output logic [LEN_W-1:0]   wr_count
);
  seq_state_e         state;
  logic [CHUNK_W-1:0] chunk_left;
  logic               dev_busy;
  logic               err_q;
  logic               xfer;

  always_comb begin
    spi_cs_n     = 1'b0;
    spi_tx_valid = 1'b1;
    spi_tx_data  = OP_FILL;
    case (state)
      S_POLL_OP: spi_tx_data = OP_STATUS;
      S_POLL_RD: spi_tx_data = OP_FILL;
      S_WREN:    spi_tx_data = OP_WREN;
      S_PP_OP:   spi_tx_data = OP_PROG;
      S_PP_A2:   spi_tx_data = cur_addr[23:16];
      S_PP_A1:   spi_tx_data = cur_addr[15:8];
      S_PP_A0:   spi_tx_data = cur_addr[7:0];
      S_PP_DAT: begin
        spi_tx_data  = in_data;
        spi_tx_valid = in_valid;
      end
      default: begin
        spi_cs_n     = 1'b1;
        spi_tx_valid = 1'b0;
      end
    endcase
  end

  assign xfer      = spi_tx_valid && spi_tx_ready;
  assign in_ready  = (state == S_PP_DAT) && spi_tx_ready;
  assign req_ready = (state == S_IDLE);
  assign done      = (state == S_DONE);
  assign err       = err_q;
  assign poll_clr  = (state == S_IDLE) || (state == S_PP_GAP);
  assign poll_inc  = (state == S_POLL_GAP) && dev_busy && !poll_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cur_addr   <= '0;
      remain     <= '0;
      chunk_left <= '0;
      wr_count   <= '0;
      dev_busy   <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          wr_count <= '0;
          err_q    <= req_oor && !req_empty;
          cur_addr <= req_addr;
          remain   <= req_len;
          state    <= (req_empty || req_oor) ? S_DONE : S_POLL_OP;
        end
        S_POLL_OP: if (xfer) state <= S_POLL_RD;
        S_POLL_RD: if (xfer) begin
          dev_busy <= |(spi_rx_data & BUSY_MASK);
          state    <= S_POLL_GAP;
        end
        S_POLL_GAP: begin
          if (!dev_busy) state <= S_WREN;
          else if (poll_last) begin
            err_q <= 1'b1;
            state <= S_DONE;
          end else state <= S_POLL_OP;
        end
        S_WREN: if (xfer) state <= S_WREN_GAP;
        S_WREN_GAP: begin
          chunk_left <= chunk_len;
          state      <= S_PP_OP;
        end
        S_PP_OP: if (xfer) state <= S_PP_A2;
        S_PP_A2: if (xfer) state <= S_PP_A1;
        S_PP_A1: if (xfer) state <= S_PP_A0;
        S_PP_A0: if (xfer) state <= S_PP_DAT;
        S_PP_DAT: if (xfer) begin
          cur_addr   <= cur_addr + ADDR_W'(1);
          remain     <= remain - LEN_W'(1);
          wr_count   <= wr_count + LEN_W'(1);
          chunk_left <= chunk_left - CHUNK_W'(1);
          if (chunk_left == CHUNK_W'(1)) state <= S_PP_GAP;
        end
        S_PP_GAP: state <= (remain == '0) ? S_DONE : S_POLL_OP;
        default:  state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pp_split_top.sv
module pp_split_top
  import pp_split_pkg::*;
#(
  parameter int          PAGE_BYTES = 256,
  parameter int          LEN_W      = 16,
  parameter int unsigned DEV_BYTES  = 32'd16777216,
  parameter int          POLL_MAX   = 100000,
  localparam int         PAGE_W     = $clog2(PAGE_BYTES),
  localparam int         CHUNK_W    = PAGE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              spi_cs_n,
  output logic              spi_tx_valid,
  input  logic              spi_tx_ready,
  output logic [7:0]        spi_tx_data,
  input  logic [7:0]        spi_rx_data,
  output logic              done,
  output logic              err,
  output logic [LEN_W-1:0]  wr_count
);
  logic               req_empty, req_oor;
  logic [ADDR_W-1:0]  cur_addr;
  logic [LEN_W-1:0]   remain;
  logic [CHUNK_W-1:0] chunk_len;
  logic               poll_clr, poll_inc, poll_last;

  pp_req_check #(.LEN_W(LEN_W), .DEV_BYTES(DEV_BYTES)) u_check (
    .addr(req_addr), .len(req_len), .is_empty(req_empty), .out_of_range(req_oor)
  );

  pp_chunk_calc #(.PAGE_BYTES(PAGE_BYTES), .LEN_W(LEN_W)) u_chunk (
    .page_off(cur_addr[PAGE_W-1:0]), .remain(remain), .chunk_len(chunk_len)
  );

  pp_poll_limit #(.POLL_MAX(POLL_MAX)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(poll_clr), .inc(poll_inc), .last(poll_last)
  );

  pp_split_seq #(.LEN_W(LEN_W), .CHUNK_W(CHUNK_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
    .req_empty(req_empty), .req_oor(req_oor),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .spi_cs_n(spi_cs_n), .spi_tx_valid(spi_tx_valid), .spi_tx_ready(spi_tx_ready),
    .spi_tx_data(spi_tx_data), .spi_rx_data(spi_rx_data),
    .cur_addr(cur_addr), .remain(remain), .chunk_len(chunk_len),
    .poll_clr(poll_clr), .poll_inc(poll_inc), .poll_last(poll_last),
    .done(done), .err(err), .wr_count(wr_count)
  );
endmodule

// File: rtl/pp_split_chk.sv
module pp_split_chk #(
  parameter int          LEN_W     = 16,
  parameter int unsigned DEV_BYTES = 32'd16777216
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [23:0]      req_addr,
  input logic [LEN_W-1:0] req_len,
  input logic             in_valid,
  input logic             in_ready,
  input logic             spi_cs_n,
  input logic             spi_tx_valid,
  input logic             done,
  input logic             err,
  input logic [LEN_W-1:0] wr_count
);
  logic req_take, req_bad;
  assign req_take = req_valid && req_ready;
  assign req_bad  = (33'(req_addr) + 33'(req_len)) > 33'(DEV_BYTES);

  p_tx_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_tx_valid |-> !spi_cs_n);

  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (wr_count == $past(wr_count) + LEN_W'(1)));

  p_count_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !(in_valid && in_ready)) |=> $stable(wr_count));

  p_empty_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_take && req_len == '0) |=> (done && !err && spi_cs_n && wr_count == '0));

  p_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_take && req_len != '0 && req_bad) |=> (done && err && spi_cs_n));

  p_stream_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!spi_cs_n && !req_ready));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (spi_cs_n && !done));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind pp_split_top pp_split_chk #(.LEN_W(LEN_W), .DEV_BYTES(DEV_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_len(req_len), .in_valid(in_valid), .in_ready(in_ready),
  .spi_cs_n(spi_cs_n), .spi_tx_valid(spi_tx_valid), .done(done), .err(err),
  .wr_count(wr_count)
);

// File: tb/pp_split_top_tb.sv
module pp_split_top_tb;
  localparam int LEN_W = 16;
  localparam int DEV   = 65536;
  localparam int PMAX  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid = 1'b0, req_ready;
  logic [23:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic in_valid, in_ready;
  logic [7:0] in_data;
  logic spi_cs_n, spi_tx_valid, spi_tx_ready;
  logic [7:0] spi_tx_data, spi_rx_data;
  logic done, err;
  logic [LEN_W-1:0] wr_count;

  pp_split_top #(.LEN_W(LEN_W), .DEV_BYTES(DEV), .POLL_MAX(PMAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .spi_cs_n(spi_cs_n), .spi_tx_valid(spi_tx_valid),
    .spi_tx_ready(spi_tx_ready), .spi_tx_data(spi_tx_data), .spi_rx_data(spi_rx_data),
    .done(done), .err(err), .wr_count(wr_count)
  );

  int n_chk = 0, n_bad = 0;
  int busy_left = 0, busy_after = 0, data_idx = 0, scen_start = 0, cyc = 0;
  bit stall_tx = 0, gap_in = 0, stream_on = 0, in_frame = 0;
  logic [7:0] cur_op = '0;
  int cur_cnt = 0, cur_addr = 0, nf = 0, data_bad = 0, gate_bad = 0, cs_low = 0;
  int fop[256], flen[256], faddr[256];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int k);
    return 8'(k ^ (k >> 8) ^ 8'h5A);
  endfunction

  // Flash and stream source model: drive at the falling edge, observe 1 ns later.
  initial begin
    spi_tx_ready = 1'b0; spi_rx_data = '0; in_valid = 1'b0; in_data = '0;
    forever begin
      @(negedge clk);
      cyc++;
      spi_tx_ready = stall_tx ? (cyc % 2 == 0) : 1'b1;
      in_valid     = stream_on && (!gap_in || (cyc % 3 != 0));
      in_data      = pat(data_idx);
      spi_rx_data  = (in_frame && cur_op == 8'h05 && cur_cnt == 1 && busy_left > 0) ? 8'h03 : 8'hFE;
      #1;
      if (spi_cs_n) begin
        if (in_frame) begin
          if (nf < 256) begin fop[nf] = cur_op; flen[nf] = cur_cnt; faddr[nf] = cur_addr; end
          if (cur_op == 8'h02) busy_left = busy_after;
          nf++;
          in_frame = 0;
        end
      end else begin
        cs_low++;
        if (!in_frame) begin in_frame = 1; cur_cnt = 0; cur_op = '0; cur_addr = 0; end
        if (spi_tx_valid && spi_tx_ready) begin
          if (cur_cnt == 0) cur_op = spi_tx_data;
          else if (cur_cnt < 4) cur_addr = (cur_addr << 8) | int'(spi_tx_data);
          else if (cur_op == 8'h02 && spi_tx_data != pat(cur_addr + cur_cnt - 4 - scen_start))
            data_bad++;
          if (cur_op == 8'h05 && cur_cnt == 1 && busy_left > 0) busy_left--;
          cur_cnt++;
        end
      end
      if (in_valid && in_ready) begin
        if (spi_cs_n || cur_op != 8'h02 || cur_cnt < 5) gate_bad++;
        data_idx++;
      end
    end
  end

  task automatic do_req(input int start, input int len, input int bf, input int ba,
                        input bit stall, input bit gap, output bit e, output int cnt);
    int w;
    @(posedge clk); #2;
    nf = 0; data_bad = 0; gate_bad = 0; cs_low = 0; data_idx = 0; scen_start = start;
    busy_left = bf; busy_after = ba; stall_tx = stall; gap_in = gap; stream_on = 1;
    req_addr = 24'(start); req_len = LEN_W'(len); req_valid = 1'b1;
    @(posedge clk); #2;
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R10 busy after accept", int'(req_ready), 0);
    for (w = 0; w < 20000; w++) begin
      if (done) break;
      @(posedge clk); #2;
    end
    check(w < 20000, "R10 done seen", w, 0);
    e = err; cnt = int'(wr_count);
    stream_on = 0;
    @(posedge clk); #2;
    check(done == 1'b0, "R10 done single pulse", int'(done), 0);
  endtask

  // Walks the recorded frames against the chunk rules.
  task automatic verify_ok(input int start, input int len, input int pf, input int pl);
    int idx = 0, a = start, r = len, k = 0, mism = 0, c;
    while (r > 0) begin
      for (int p = 0; p < ((k == 0) ? pf : pl); p++) begin
        if (fop[idx] != 5 || flen[idx] != 2) mism++;
        idx++;
      end
      if (fop[idx] != 6 || flen[idx] != 1) mism++;
      idx++;
      c = 256 - (a % 256);
      if (r < c) c = r;
      check(fop[idx] == 2, "R3 program opcode", fop[idx], 2);
      check(faddr[idx] == a, (k == 0) ? "R1 chunk address" : "R2 chunk address", faddr[idx], a);
      check(flen[idx] == c + 4, (k == 0) ? "R1 chunk length" : "R2 chunk length", flen[idx] - 4, c);
      idx++; a += c; r -= c; k++;
    end
    check(mism == 0, "R4 poll and write-enable frames", mism, 0);
    check(nf == idx, "R11 frame count", nf, idx);
    check(data_bad == 0, "R3 data bytes", data_bad, 0);
    check(gate_bad == 0, "R9 stream gating", gate_bad, 0);
    check(data_idx == len, "R9 stream bytes consumed", data_idx, len);
  endtask

  task automatic t_reset();
    check(spi_cs_n == 1'b1 && spi_tx_valid == 1'b0, "R3 reset bus idle", int'(spi_cs_n), 1);
    check(req_ready == 1'b1 && done == 1'b0, "R10 reset ready", int'(req_ready), 1);
    check(in_ready == 1'b0, "R9 reset stream held", int'(in_ready), 0);
    check(wr_count == '0, "R5 reset count", int'(wr_count), 0);
  endtask

  task automatic t_normal(input int start, input int len, input int bf, input int ba,
                          input bit stall, input bit gap);
    bit e; int cnt;
    do_req(start, len, bf, ba, stall, gap, e, cnt);
    check(e == 1'b0, "R5 no error", int'(e), 0);
    check(cnt == len, "R5 written count", cnt, len);
    verify_ok(start, len, bf + 1, ba + 1);
  endtask

  task automatic t_empty();
    bit e; int cnt;
    do_req(32'h10, 0, 0, 0, 0, 0, e, cnt);
    check(e == 1'b0, "R6 empty no error", int'(e), 0);
    check(cnt == 0, "R6 empty count", cnt, 0);
    check(cs_low == 0, "R6 empty no bus", cs_low, 0);
    check(data_idx == 0, "R6 empty stream untouched", data_idx, 0);
  endtask

  task automatic t_range();
    bit e; int cnt;
    do_req(32'hFF00, 32'h101, 0, 0, 0, 0, e, cnt);
    check(e == 1'b1, "R7 reject error", int'(e), 1);
    check(cnt == 0, "R7 reject count", cnt, 0);
    check(cs_low == 0, "R7 reject no bus", cs_low, 0);
    check(data_idx == 0, "R7 reject stream untouched", data_idx, 0);
    t_normal(32'hFF00, 32'h100, 0, 0, 0, 0); // R7 exact end accepted
  endtask

  task automatic t_timeout_first();
    bit e; int cnt, polls = 0;
    do_req(32'h40, 8, 10, 0, 0, 0, e, cnt);
    for (int i = 0; i < nf && i < 256; i++) if (fop[i] == 5 && flen[i] == 2) polls++;
    check(e == 1'b1, "R8 first timeout error", int'(e), 1);
    check(cnt == 0, "R8 first timeout count", cnt, 0);
    check(nf == PMAX && polls == PMAX, "R8 first timeout polls only", nf, PMAX);
  endtask

  task automatic t_timeout_later();
    bit e; int cnt;
    do_req(32'hF0, 32'h20, 0, 10, 0, 0, e, cnt);
    check(e == 1'b1, "R8 later timeout error", int'(e), 1);
    check(cnt == 16, "R8 later timeout count", cnt, 16);
    check(nf == 3 + PMAX, "R8 later timeout frames", nf, 3 + PMAX);
    check(fop[2] == 2 && flen[2] == 20 && faddr[2] == 32'hF0, "R1 chunk before timeout", flen[2], 20);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;
    t_reset();
    t_normal(32'h000100, 16, 0, 0, 0, 0);   // R1 aligned, fits
    t_normal(32'h0000F0, 304, 0, 0, 0, 0);  // R1 R2 three chunks
    t_empty();                              // R6 also clears prior count
    t_normal(32'h80, 128, 0, 0, 0, 0);      // R1 ends exactly on boundary
    t_normal(32'h80, 129, 1, 0, 0, 0);      // R2 one byte spills
    t_normal(32'h1234, 600, 2, 1, 1, 1);    // R4 R9 polls and stalls
    t_range();
    t_timeout_first();
    t_timeout_later();
    t_normal(32'h300, 40, 0, 0, 1, 0);      // R8 recovery after error
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog: actual=%0d expected=%0d", 200000, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule